// File: doc/BRIEF.md
# Serial Register Access Slave

This block gives a host access to a bank of 32 byte-wide registers over a chip-select-framed serial link. Every transaction opens with one instruction byte that says read or write, how many data bytes follow (one to four) and the starting register address. The data bytes follow, and the internal address steps once after each byte. While chip select stays low, bits beyond the announced byte count are ignored.

Register 00h is the port's own configuration. One bit selects the bit order on the wire, and that same bit sets the direction in which the address steps. A second bit selects between two wirings: one bidirectional data pin, or a separate output pin. A third bit, which clears itself, restores every other register to its power-on value. A write to 00h acts from the next serial bit onward, even inside a multibyte transaction.

The serial clock, chip select and data input are sampled by a faster system clock. The pin drivers are shown as data and output-enable pairs, and the pad ring builds the tristate buffers from them.

Top module: `spi_reg_slave`

## Requirements
- R1: While `rst_n` is low and after it rises, register 00h reads 00h and both output enables are low.
- R2: The instruction byte carries bit 7 = 1 for read and 0 for write, bits 6:5 = number of data bytes minus one, and bits 4:0 = starting address.
- R3: With 00h bit 6 = 0 (default), each byte travels most significant bit first and the address decrements after each data byte.
- R4: With 00h bit 6 = 1, each byte, the instruction included, travels least significant bit first and the address increments after each data byte.
- R5: Address stepping wraps: decrementing from 00h gives 1Fh, and incrementing from 1Fh gives 00h.
- R6: A byte written to 00h changes bit order and step direction from the next serial bit onward, including the step that follows that byte.
- R7: Writing 00h with bit 5 = 1 returns registers 01h..1Fh to their defaults, keeps 00h bits 7:6 as written, and 00h bit 5 reads back as 0.
- R8: With 00h bit 7 = 1, read data appears on `sdo` with `sdo_oe` high and `sdio_oe` low. With bit 7 = 0, read data appears on `sdio_out` with `sdio_oe` high, and `sdo_oe` stays low. The two enables are never high together.
- R9: Input bits are taken on the rising edge of `sclk`. Read bits change on the falling edge and hold until the next falling edge.
- R10: Raising `cs_n` ends the transaction at any bit. A partial byte is discarded, both enables drop, and the next frame starts with an instruction byte.
- R11: Bits sent after the announced number of data bytes, while `cs_n` stays low, change no register.
- R12: After reset, register k (01h..1Fh) holds {101b, k}, and register 00h bits 4:0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low chip select that frames a transaction |
| sdio_in | input | 1 | Serial data input (input side of the data pin) |
| sdio_out | output | 1 | Read data for the bidirectional pin |
| sdio_oe | output | 1 | Output enable of the bidirectional pin |
| sdo | output | 1 | Read data for the separate output pin |
| sdo_oe | output | 1 | Output enable of the separate output pin |

## Verification
A wrong bit counter or a wrong phase shows on the first read byte after the fault, as a rotated or shifted value, or as an output enable active in the wrong phase. A wrong step direction or a wrong wrap shows on the second byte of a multibyte read. A configuration bit that takes effect late shows on the byte right after a mid-transaction write to 00h. A soft reset that misses a register shows on the next single-byte read of that register.

// File: rtl/spi_regs_pkg.sv
// Package: shared constants, frame phase type and register reset values.
// Assumes an 8-bit instruction of {rw, count[1:0], addr[4:0]}.
package spi_regs_pkg;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 8;
    localparam int CNT_W   = 2;
    localparam int NREG    = 1 << ADDR_W;
    localparam int BIT_W   = $clog2(DATA_W);

    // Configuration bit positions in register 00h
    localparam int CFG_WIRE4 = 7;
    localparam int CFG_LSB   = 6;
    localparam int CFG_SRST  = 5;

    typedef enum logic [1:0] {
        PH_INSTR = 2'd0,
        PH_DATA  = 2'd1,
        PH_DONE  = 2'd2
    } phase_t;

    // Power-on value of a register: 00h is zero, others {101b, address}
    function automatic logic [DATA_W-1:0] reg_default(input logic [ADDR_W-1:0] a);
        return (a == '0) ? '0 : {3'b101, a};
    endfunction
endpackage

// File: rtl/spi_reg_frame.sv
// Frame controller: counts serial bits, assembles bytes in the selected
// order, decodes the instruction, steps the address and issues writes.
// Assumes sclk_rise is a one-clock pulse and cs_n is already synchronous.
module spi_reg_frame
    import spi_regs_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              cs_n,
    input  logic              din,
    input  logic              cfg_lsb,
    output phase_t            phase,
    output logic              rw,
    output logic [BIT_W-1:0]  bit_cnt,
    output logic [AW-1:0]     addr,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] nxt;
    logic [CNT_W-1:0]  left;
    logic              byte_end;
    logic              step_lsb;
    logic [AW-1:0]     step_addr;

    // Next shift value in the current bit order
    assign nxt = cfg_lsb ? {din, shreg[DATA_W-1:1]} : {shreg[DATA_W-2:0], din};
    assign byte_end = sclk_rise && !cs_n && (bit_cnt == BIT_W'(DATA_W-1));

    // Write strobe towards the register bank at the end of a data byte
    assign wr_en   = byte_end && (phase == PH_DATA) && !rw;
    assign wr_addr = addr;
    assign wr_data = nxt;

    // Step direction honours a bit order written by this very byte
    assign step_lsb  = (wr_en && addr == '0) ? nxt[CFG_LSB] : cfg_lsb;
    assign step_addr = step_lsb ? addr + 1'b1 : addr - 1'b1;

    // Phase, bit count, instruction fields and address sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_INSTR;
            bit_cnt <= '0;
            shreg   <= '0;
            rw      <= 1'b0;
            left    <= '0;
            addr    <= '0;
        end else if (cs_n) begin
            phase   <= PH_INSTR;
            bit_cnt <= '0;
        end else if (sclk_rise && phase != PH_DONE) begin
            shreg   <= nxt;
            bit_cnt <= bit_cnt + 1'b1;
            if (byte_end) begin
                if (phase == PH_INSTR) begin
                    rw    <= nxt[7];
                    left  <= nxt[6:5];
                    addr  <= nxt[AW-1:0];
                    phase <= PH_DATA;
                end else begin
                    addr <= step_addr;
                    if (left == '0) phase <= PH_DONE;
                    else            left  <= left - 1'b1;
                end
            end
        end
    end

    // Shift state only moves on a rising serial edge
    assert_hold_between_edges_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !sclk_rise) |=> ($stable(bit_cnt) && $stable(shreg)));

    // Deselect returns to the instruction phase at bit zero
    assert_abort_to_instr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (phase == PH_INSTR && bit_cnt == '0));

    // Once the byte count is used up, nothing moves until deselect
    assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE && !cs_n) |=> (phase == PH_DONE && $stable(addr)));

    // Address wraps downward from 00h in most-significant-first order
    assert_wrap_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && phase == PH_DATA && addr == '0 && !step_lsb) |=> (addr == '1));

    // Address wraps upward from 1Fh in least-significant-first order
    assert_wrap_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && phase == PH_DATA && addr == '1 && step_lsb) |=> (addr == '0));
endmodule

// File: rtl/spi_reg_bank.sv
// Register bank: configuration register 00h plus 31 data registers with
// per-address defaults; soft reset restores the data registers only.
// Assumes one write strobe per data byte from the frame controller.
module spi_reg_bank
    import spi_regs_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NR = NREG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              cfg_lsb,
    output logic              cfg_wire4
);
    localparam int BANK_W = NR * DATA_W;

    logic [BANK_W-1:0] bank;
    logic              cfg_wr;
    logic              soft_rst;

    assign cfg_wr   = wr_en && (wr_addr == '0);
    assign soft_rst = cfg_wr && wr_data[CFG_SRST];

    // Configuration bits update on the write that ends the byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_lsb   <= 1'b0;
            cfg_wire4 <= 1'b0;
        end else if (cfg_wr) begin
            cfg_lsb   <= wr_data[CFG_LSB];
            cfg_wire4 <= wr_data[CFG_WIRE4];
        end
    end

    assign bank[DATA_W-1:0] = {cfg_wire4, cfg_lsb, {(DATA_W-2){1'b0}}};

    for (genvar g = 1; g < NR; g++) begin : g_reg
        localparam logic [DATA_W-1:0] DEF = reg_default(AW'(g));
        logic [DATA_W-1:0] val;

        // One data register: reset or soft reset to default, else write
        always_ff @(posedge clk) begin
            if (!rst_n)                              val <= DEF;
            else if (soft_rst)                       val <= DEF;
            else if (wr_en && wr_addr == AW'(g))     val <= wr_data;
        end

        assign bank[g*DATA_W +: DATA_W] = val;

        assert_soft_reset_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
            soft_rst |=> (val == DEF));
    end

    assign rd_data = bank[{rd_addr, {BIT_W{1'b0}}} +: DATA_W];

    // Configuration only changes through a write to 00h
    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ($stable(cfg_lsb) && $stable(cfg_wire4)));

    // Soft reset keeps the written port configuration
    assert_soft_reset_keeps_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cfg_lsb == $past(wr_data[CFG_LSB]) && cfg_wire4 == $past(wr_data[CFG_WIRE4])));
endmodule

// File: rtl/spi_reg_slave.sv
// Top level: edge detection on sclk, frame controller, register bank and
// read-data driver with separate enables for the two wiring modes.
// Assumes sclk, cs_n and sdio_in are synchronous to clk; sclk idles low.
module spi_reg_slave
    import spi_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdio_in,
    output logic sdio_out,
    output logic sdio_oe,
    output logic sdo,
    output logic sdo_oe
);
    logic              sclk_q;
    logic              sclk_rise;
    logic              sclk_fall;
    phase_t            phase;
    logic              rw;
    logic [BIT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] addr;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic              cfg_lsb;
    logic              cfg_wire4;
    logic              out_q;
    logic              reading;
    logic              out_bit;

    assign sclk_rise = sclk && !sclk_q;
    assign sclk_fall = !sclk && sclk_q;

    spi_reg_frame #(.AW(ADDR_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_rise(sclk_rise),
        .cs_n     (cs_n),
        .din      (sdio_in),
        .cfg_lsb  (cfg_lsb),
        .phase    (phase),
        .rw       (rw),
        .bit_cnt  (bit_cnt),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    spi_reg_bank #(.AW(ADDR_W), .NR(NREG)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (addr),
        .rd_data  (rd_data),
        .cfg_lsb  (cfg_lsb),
        .cfg_wire4(cfg_wire4)
    );

    // Bit of the current read byte selected by order and bit count
    assign out_bit = cfg_lsb ? rd_data[bit_cnt] : rd_data[BIT_W'(DATA_W-1) - bit_cnt];
    assign reading = !cs_n && (phase == PH_DATA) && rw;

    // Serial clock history and read bit launched on the falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            out_q  <= 1'b0;
        end else begin
            sclk_q <= sclk;
            if (sclk_fall && reading) out_q <= out_bit;
        end
    end

    assign sdo      = out_q;
    assign sdio_out = out_q;
    assign sdo_oe   = reading && cfg_wire4;
    assign sdio_oe  = reading && !cfg_wire4;

    // Read bit holds between falling serial edges
    assert_read_bit_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(out_q));

    // Only one pin drives read data, and never outside a read phase
    assert_one_driver_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!sdo_oe && !sdio_oe));
endmodule

// File: tb/spi_reg_slave_test.sv
// Bench: behavioural model of the register space and port configuration,
// bit-level serial driver, read-back comparison and per-clock pin checks.
module spi_reg_slave_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic sdio_in = 1'b0;
    logic sdio_out, sdio_oe, sdo, sdo_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] m_reg [32];
    logic       m_lsb = 1'b0;
    logic       m_4w  = 1'b0;
    logic [7:0] wbuf [4];
    logic [7:0] rbuf [4];
    logic       cs_prev = 1'b1;

    always #5 clk = ~clk;

    spi_reg_slave uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    function automatic logic [7:0] def_val(input int a);
        return (a == 0) ? 8'h00 : {3'b101, 5'(a)};
    endfunction

    function automatic logic [7:0] model_read(input int a);
        return (a == 0) ? {m_4w, m_lsb, 6'b0} : m_reg[a];
    endfunction

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-clock pin checks against the model, sampled after the edge
    always @(posedge clk) begin
        #3;
        if (rst_n) begin
            chk(!(sdo_oe && sdio_oe), "R8 both enables", {sdo_oe, sdio_oe}, 0);
            if (cs_prev) chk(!sdo_oe && !sdio_oe, "R10 enable while deselected", {sdo_oe, sdio_oe}, 0);
            if (!m_4w && cs_prev) chk(!sdo_oe, "R8 sdo_oe in 3-wire", sdo_oe, 0);
        end
        cs_prev = cs_n;
    end

    // One serial bit: drive on low phase, sample read data before rising edge
    task automatic spi_bit(input logic b, output logic got, output logic oe_ok);
        @(negedge clk);
        sclk = 1'b0;
        sdio_in = b;
        repeat (4) @(negedge clk);
        got   = m_4w ? sdo : sdio_out;
        oe_ok = m_4w ? (sdo_oe && !sdio_oe) : (sdio_oe && !sdo_oe);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input int nbits);
        logic g, o;
        for (int i = 0; i < nbits; i++) spi_bit(m_lsb ? b[i] : b[7-i], g, o);
    endtask

    task automatic recv_byte(output logic [7:0] r, output bit oe_all);
        logic g, o;
        oe_all = 1'b1;
        r = '0;
        for (int i = 0; i < 8; i++) begin
            spi_bit(1'b0, g, o);
            if (m_lsb) r[i] = g; else r[7-i] = g;
            oe_all &= o;
        end
    endtask

    task automatic model_write(input int a, input logic [7:0] b);
        if (a == 0) begin
            m_lsb = b[6];
            m_4w  = b[7];
            if (b[5]) for (int k = 1; k < 32; k++) m_reg[k] = def_val(k);
        end else begin
            m_reg[a] = b;
        end
    endtask

    task automatic frame_end();
        @(negedge clk);
        sclk = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Full transaction; extra bytes are sent after the counted ones
    task automatic xfer(input bit rd, input int n, input int a, input int extra, input string tag);
        int cur = a;
        logic [7:0] r;
        bit oe;
        @(negedge clk);
        cs_n = 1'b0;
        send_byte({rd, 2'(n - 1), 5'(a)}, 8);
        for (int i = 0; i < n; i++) begin
            if (rd) begin
                recv_byte(r, oe);
                rbuf[i] = r;
                chk(r == model_read(cur), $sformatf("%s R9 read byte addr %0h", tag, cur), r, model_read(cur));
                chk(oe, $sformatf("%s R8 enable on read pin", tag), oe, 1);
            end else begin
                send_byte(wbuf[i], 8);
                model_write(cur, wbuf[i]);
            end
            cur = m_lsb ? (cur + 1) % 32 : (cur + 31) % 32;
        end
        for (int e = 0; e < extra; e++) send_byte(8'hFF, 8);
        frame_end();
    endtask

    task automatic read1(input int a, input string tag);
        xfer(1'b1, 1, a, 0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 32; k++) m_reg[k] = def_val(k);
        repeat (5) @(negedge clk);
        chk(!sdo_oe && !sdio_oe, "R1 enables in reset", {sdo_oe, sdio_oe}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!sdo_oe && !sdio_oe, "R1 enables after reset", {sdo_oe, sdio_oe}, 0);

        // R1, R12: defaults through single reads
        read1(0, "R1 cfg");
        read1(5, "R12 default");
        read1(31, "R12 default top");

        // R2, R3: three-byte write, decrementing from 12h
        wbuf[0] = 8'h3C; wbuf[1] = 8'h81; wbuf[2] = 8'h5A;
        xfer(1'b0, 3, 18, 0, "R3 write");
        read1(18, "R3 msb byte");
        read1(17, "R3 next");
        read1(16, "R3 last");

        // R5: four-byte read wrapping down through 00h
        xfer(1'b1, 4, 2, 0, "R5 wrap down");

        // R4: switch to least-significant-first
        wbuf[0] = 8'h40;
        xfer(1'b0, 1, 0, 0, "R4 set order");
        wbuf[0] = 8'hC3; wbuf[1] = 8'h17;
        xfer(1'b0, 2, 30, 0, "R4 write up");
        xfer(1'b1, 4, 31, 0, "R5 wrap up");
        read1(30, "R4 lsb read");

        // R8: four-wire wiring, read on separate pin
        wbuf[0] = 8'hC0;
        xfer(1'b0, 1, 0, 0, "R8 set wire4");
        xfer(1'b1, 2, 16, 0, "R8 wire4 read");

        // R6: write 00h mid-frame in lsb order, next byte msb order, step down
        wbuf[0] = 8'h80; wbuf[1] = 8'h96;
        xfer(1'b0, 2, 0, 0, "R6 mid-frame");
        read1(31, "R6 after switch");
        read1(0, "R6 cfg");

        // R7: soft reset keeps 00h order/wiring, restores the rest
        wbuf[0] = 8'h22;
        xfer(1'b0, 1, 9, 0, "R7 prep");
        wbuf[0] = 8'hA0;
        xfer(1'b0, 1, 0, 0, "R7 soft reset");
        read1(0, "R7 cfg kept");
        read1(9, "R7 restored");
        read1(18, "R7 restored");
        read1(31, "R7 restored");

        // R10: abort inside instruction, then inside a write data byte
        @(negedge clk); cs_n = 1'b0;
        send_byte({1'b0, 2'd0, 5'd7}, 5);
        frame_end();
        read1(7, "R10 after instr abort");
        @(negedge clk); cs_n = 1'b0;
        send_byte({1'b0, 2'd0, 5'd7}, 8);
        send_byte(8'h00, 4);
        frame_end();
        read1(7, "R10 partial byte dropped");

        // R11: surplus bytes after the count change nothing
        wbuf[0] = 8'h44;
        xfer(1'b0, 1, 8, 2, "R11 surplus");
        read1(8, "R11 counted byte");
        read1(7, "R11 neighbour");
        read1(6, "R11 neighbour");

        // Back to three-wire, msb order for a last read pattern
        wbuf[0] = 8'h00;
        xfer(1'b0, 1, 0, 0, "R8 set wire3");
        xfer(1'b1, 3, 8, 0, "R8 wire3 read");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule